// File: doc/BRIEF.md
# BCD Alarm Repeat Controller

This block holds a four-field alarm setting (second, minute, hour, day of month), each field a BCD byte written over a byte-wide register bus. It compares the unmasked fields against BCD time values from an external timekeeping counter. When a one-second tick arrives while the programmed condition holds, it raises a one-cycle interrupt pulse.

Bit 7 of every alarm byte is a mask flag. The combination of flags picks how often the alarm repeats: once a month, once a day, once an hour, once a minute or once a second. Each write is range-checked after BCD decoding. A write whose value is out of range is dropped without any notice, and the register keeps its previous byte.

Top module: `alarm_repeat_ctrl`

## Requirements
- R1: After reset all four alarm bytes read 0x00 and `irq` is low.
- R2: The alarm bytes sit at four consecutive bus addresses starting at `BASE_ADDR`: second at +0, minute at +1, hour at +2, date at +3. `rdata` shows the byte at `addr` in the same cycle, and reads 0x00 for any other address.
- R3: A second or minute write is accepted only when bits [6:4]×10 + bits [3:0] of the written byte is at most 59.
- R4: An hour write is accepted only when bits [5:4]×10 + bits [3:0] of the written byte is at most 23.
- R5: A date write is accepted only when bit [4]×10 + bits [3:0] of the written byte lies in 1..31.
- R6: An accepted write stores the whole byte, bit 7 included, and that byte reads back in the following cycle. A rejected write leaves the stored byte unchanged.
- R7: With all four mask bits clear, the match compares date (bits [4:0]), hour (bits [5:0]), minute (bits [6:0]) and second (bits [6:0]) against the time inputs.
- R8: With only the date mask set, the match compares hour, minute and second.
- R9: With the date and hour masks set and the others clear, the match compares minute and second.
- R10: With the date, hour and minute masks set and the second mask clear, the match compares the second alone.
- R11: Any other mask pattern, including all four set, matches on every tick.
- R12: `irq` is high for exactly the one cycle that follows a clock edge at which `sec_tick` was high and the match held. It is never high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| tm_sec | input | 8 | Current second, BCD |
| tm_min | input | 8 | Current minute, BCD |
| tm_hour | input | 8 | Current hour, BCD |
| tm_date | input | 8 | Current day of month, BCD |
| sec_tick | input | 1 | One-second tick from the time counter |
| irq | output | 1 | Alarm interrupt pulse |

## Verification
A write takes effect at the clock edge where `wr_en` is sampled. Read data is combinational, so the bench drives a write on a falling edge, steps past the next rising edge, and then presents the address and samples `rdata` one time unit later. The interrupt comes from a single register. The bench therefore drives `sec_tick` and the time inputs on a falling edge and samples `irq` just after the following rising edge. It then samples again one cycle later, with the tick removed, to confirm that the pulse lasted exactly one cycle.

// File: rtl/alarm_repeat_ctrl.sv
module alarm_repeat_ctrl #(
  parameter int ADDR_W    = 13,
  parameter int BASE_ADDR = 32'h1FF2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [7:0]        tm_sec,
  input  logic [7:0]        tm_min,
  input  logic [7:0]        tm_hour,
  input  logic [7:0]        tm_date,
  input  logic              sec_tick,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'(BASE_ADDR + 1);
  localparam logic [ADDR_W-1:0] A_HOUR = ADDR_W'(BASE_ADDR + 2);
  localparam logic [ADDR_W-1:0] A_DATE = ADDR_W'(BASE_ADDR + 3);

  function automatic logic [7:0] bcd_dec(input logic [3:0] hi, input logic [3:0] lo);
    return 8'(hi) * 8'd10 + 8'(lo);
  endfunction

  logic [7:0] al_sec, al_min, al_hour, al_date;
  logic       irq_q;

  wire [7:0] v_sec  = bcd_dec({1'b0, wdata[6:4]}, wdata[3:0]);
  wire [7:0] v_hour = bcd_dec({2'b0, wdata[5:4]}, wdata[3:0]);
  wire [7:0] v_date = bcd_dec({3'b0, wdata[4]},   wdata[3:0]);

  wire sec_ok  = v_sec  <= 8'd59;
  wire hour_ok = v_hour <= 8'd23;
  wire date_ok = (v_date >= 8'd1) && (v_date <= 8'd31);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      al_sec  <= 8'h00;
      al_min  <= 8'h00;
      al_hour <= 8'h00;
      al_date <= 8'h00;
    end else if (wr_en) begin
      if (addr == A_SEC  && sec_ok)  al_sec  <= wdata;
      if (addr == A_MIN  && sec_ok)  al_min  <= wdata;
      if (addr == A_HOUR && hour_ok) al_hour <= wdata;
      if (addr == A_DATE && date_ok) al_date <= wdata;
    end
  end

  always_comb begin
    unique case (addr)
      A_SEC:   rdata = al_sec;
      A_MIN:   rdata = al_min;
      A_HOUR:  rdata = al_hour;
      A_DATE:  rdata = al_date;
      default: rdata = 8'h00;
    endcase
  end

  wire eq_sec  = al_sec[6:0]  == tm_sec[6:0];
  wire eq_min  = al_min[6:0]  == tm_min[6:0];
  wire eq_hour = al_hour[5:0] == tm_hour[5:0];
  wire eq_date = al_date[4:0] == tm_date[4:0];

  wire [3:0] masks = {al_date[7], al_hour[7], al_min[7], al_sec[7]};
  logic match;

  always_comb begin
    case (masks)
      4'b0000: match = eq_date & eq_hour & eq_min & eq_sec;
      4'b1000: match = eq_hour & eq_min & eq_sec;
      4'b1100: match = eq_min & eq_sec;
      4'b1110: match = eq_sec;
      default: match = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= sec_tick & match;
  end

  assign irq = irq_q;

  assert_irq_after_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(sec_tick));

  assert_sec_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SEC && v_sec > 8'd59) |=> al_sec == $past(al_sec));

  assert_hour_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_HOUR && v_hour > 8'd23) |=> al_hour == $past(al_hour));

  assert_date_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DATE && date_ok) |=> (addr != A_DATE || rdata == $past(wdata)));

  assert_every_second_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && masks == 4'b1111) |=> irq);
endmodule

// File: tb/alarm_repeat_ctrl_tb.sv
module alarm_repeat_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 13;
  localparam logic [AW-1:0] A_S = 13'h1FF2, A_M = 13'h1FF3, A_H = 13'h1FF4, A_D = 13'h1FF5;

  logic clk = 0, rst_n = 0, wr_en = 0, sec_tick = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = 0, tm_sec = 0, tm_min = 0, tm_hour = 0, tm_date = 0;
  logic [7:0] rdata;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_repeat_ctrl #(.ADDR_W(AW), .BASE_ADDR(32'h1FF2)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour), .tm_date(tm_date),
    .sec_tick(sec_tick), .irq(irq));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a; #1; chk(req, rdata, exp);
  endtask

  task automatic tick_chk(input string req, input logic [7:0] s, input logic [7:0] m,
                          input logic [7:0] h, input logic [7:0] d, input logic exp);
    @(negedge clk); tm_sec = s; tm_min = m; tm_hour = h; tm_date = d; sec_tick = 1;
    @(posedge clk); #1; chk(req, {7'b0, irq}, {7'b0, exp});
    @(negedge clk); sec_tick = 0;
    @(posedge clk); #1; chk({req, " R12 single cycle"}, {7'b0, irq}, 8'h00);
  endtask

  task automatic set_alarm(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h, input logic [7:0] d);
    wr(A_S, s); wr(A_M, m); wr(A_H, h); wr(A_D, d);
  endtask

  task automatic t_reset;
    rd_chk("R1 sec", A_S, 8'h00); rd_chk("R1 min", A_M, 8'h00);
    rd_chk("R1 hour", A_H, 8'h00); rd_chk("R1 date", A_D, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_regs;
    set_alarm(8'h12, 8'h34, 8'h05, 8'h27);
    rd_chk("R2 sec", A_S, 8'h12); rd_chk("R2 min", A_M, 8'h34);
    rd_chk("R2 hour", A_H, 8'h05); rd_chk("R2 date", A_D, 8'h27);
    rd_chk("R2 outside", 13'h1FF6, 8'h00);
  endtask

  task automatic t_validate;
    wr(A_S, 8'h59); rd_chk("R3 sec 59 ok", A_S, 8'h59);
    wr(A_S, 8'h60); rd_chk("R3 sec 60 drop", A_S, 8'h59);
    wr(A_S, 8'h5A); rd_chk("R3 sec 5A drop", A_S, 8'h59);
    wr(A_M, 8'h00); rd_chk("R3 min 00 ok", A_M, 8'h00);
    wr(A_M, 8'h7F); rd_chk("R3 min 7F drop", A_M, 8'h00);
    wr(A_H, 8'h23); rd_chk("R4 hour 23 ok", A_H, 8'h23);
    wr(A_H, 8'h24); rd_chk("R4 hour 24 drop", A_H, 8'h23);
    wr(A_D, 8'h00); rd_chk("R5 date 00 drop", A_D, 8'h27);
    wr(A_D, 8'h20); rd_chk("R5 date 20 drop", A_D, 8'h27);
    wr(A_D, 8'h01); rd_chk("R5 date 01 ok", A_D, 8'h01);
    wr(A_S, 8'h85); rd_chk("R6 mask kept sec", A_S, 8'h85);
    wr(A_H, 8'hA3); rd_chk("R6 mask kept hour", A_H, 8'hA3);
    wr(A_H, 8'hB9); rd_chk("R6 invalid keeps", A_H, 8'hA3);
  endtask

  task automatic t_monthly;
    set_alarm(8'h30, 8'h15, 8'h08, 8'h12);
    tick_chk("R7 full match", 8'h30, 8'h15, 8'h08, 8'h12, 1'b1);
    tick_chk("R7 date differs", 8'h30, 8'h15, 8'h08, 8'h13, 1'b0);
    @(negedge clk); tm_date = 8'h12; sec_tick = 0;
    @(posedge clk); #1; chk("R12 no tick no irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_daily;
    set_alarm(8'h30, 8'h15, 8'h08, 8'h92);
    tick_chk("R8 date ignored", 8'h30, 8'h15, 8'h08, 8'h05, 1'b1);
    tick_chk("R8 hour differs", 8'h30, 8'h15, 8'h09, 8'h05, 1'b0);
  endtask

  task automatic t_hourly;
    set_alarm(8'h30, 8'h15, 8'h88, 8'h92);
    tick_chk("R9 hour ignored", 8'h30, 8'h15, 8'h22, 8'h05, 1'b1);
    tick_chk("R9 minute differs", 8'h30, 8'h16, 8'h22, 8'h05, 1'b0);
  endtask

  task automatic t_minute;
    set_alarm(8'h30, 8'h95, 8'h88, 8'h92);
    tick_chk("R10 minute ignored", 8'h30, 8'h40, 8'h22, 8'h05, 1'b1);
    tick_chk("R10 second differs", 8'h31, 8'h40, 8'h22, 8'h05, 1'b0);
  endtask

  task automatic t_second;
    set_alarm(8'hB0, 8'h15, 8'h08, 8'h12);
    tick_chk("R11 sec mask only", 8'h01, 8'h02, 8'h03, 8'h04, 1'b1);
    set_alarm(8'hB0, 8'h95, 8'h88, 8'h92);
    tick_chk("R11 all masks", 8'h44, 8'h33, 8'h11, 8'h21, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset; t_regs; t_validate; t_monthly; t_daily; t_hourly; t_minute; t_second;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule